// File: doc/BRIEF.md
# BCD Watchdog Interval Timer

This block is a programmable watchdog and interval timer that counts in hundredths of a second. Host software loads a four-digit BCD period, from 00.01 s to 99.99 s, into two byte-wide period registers. A hidden down-counter starts from that period and steps down by one hundredth on every cycle where the 100 Hz tick enable is high. When the count runs out, the block sets a sticky alarm flag and emits a one-cycle alarm event for a separate interrupt formatter. The counter then reloads by itself, so a host that stops servicing the timer sees the alarm repeat once per period.

The host services the watchdog by touching either period register. A read counts as a touch just as a write does. Each touch reloads the counter from the stored period and clears the flag. Reads always return the value that was entered and never the live count. A period of all zeros disables the timer. The register access port is a plain single-cycle strobe with no handshake, because the block can always accept an access in the cycle it is offered.

Top module: `wdt_bcd_timer`

## Requirements
- R1: After reset both period registers read 0x00, the flag is low and the alarm event is low.
- R2: Select 0 is the fraction register: bits 7:4 hold tenths and bits 3:0 hold hundredths. Select 1 is the seconds register: bits 7:4 hold tens of seconds and bits 3:0 hold seconds. A read returns the last value written to the selected register. Counting never changes this value.
- R3: After the last access, the alarm event pulses high in the cycle after the Nth tick-enabled clock edge, where N is the four-digit BCD period read as a decimal number of hundredths. The flag rises in the same cycle.
- R4: With no access, the alarm recurs every N ticks, and the flag stays high between alarms.
- R5: Any access, read or write, to either register clears the flag in the next cycle and restarts the full count.
- R6: When both registers hold zero, no alarm event occurs and the flag stays low, whatever the ticks do.
- R7: When an access coincides with the tick that would end the count, the access wins. No alarm event occurs and the count restarts from the full period.
- R8: The count borrows correctly across all four BCD digits. This includes periods such as 00.10, 01.00 and 99.99.
- R9: The alarm event is high for one cycle, followed by a low event when the next cycle has no expiring tick.
- R10: Clock edges without the tick enable neither advance the count nor raise the alarm event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle enable, one per hundredth of a second |
| acc_en | input | 1 | Register access strobe; a read or a write restarts the timer |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = fraction register, 1 = seconds register |
| acc_wdata | input | 8 | Write data in BCD |
| acc_rdata | output | 8 | Selected register contents (combinational) |
| wdt_flag | output | 1 | Sticky alarm flag |
| alarm_evt | output | 1 | One-cycle alarm event |

## Verification
The assertions assume that the host writes only valid BCD digits, that an access lasts exactly one cycle, and that the tick enable is a clean synchronous strobe. The stimulus keeps to these assumptions: every write value comes from BCD table entries or directed constants, and each access task raises the strobe for a single cycle. The table also varies the spacing between ticks, which exercises the rule that edges without a tick leave the count unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DIGIT_W = 4;
  localparam int BYTE_W  = 8;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  localparam bcd_digit_t BCD_MAX = 4'd9;
endpackage

// File: rtl/wdt_period_regs.sv
module wdt_period_regs #(
  parameter int N_REGS = 2,
  parameter int SEL_W  = 1,
  localparam int PW    = N_REGS * wdt_pkg::BYTE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           sel,
  input  logic [wdt_pkg::BYTE_W-1:0] wr_data,
  output logic [wdt_pkg::BYTE_W-1:0] rd_data,
  output logic [PW-1:0]              period_q,
  output logic [PW-1:0]              period_d
);
  localparam int BW = wdt_pkg::BYTE_W;

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_en && (sel == SEL_W'(r));
    assign period_d[r*BW +: BW] = hit ? wr_data : period_q[r*BW +: BW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) period_q[r*BW +: BW] <= '0;
      else if (hit) period_q[r*BW +: BW] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < N_REGS; r++) begin
      if (sel == SEL_W'(r)) rd_data = period_q[r*BW +: BW];
    end
  end
endmodule

// File: rtl/wdt_bcd_down.sv
module wdt_bcd_down #(
  parameter int N_DIGITS = 4,
  localparam int CW      = N_DIGITS * wdt_pkg::DIGIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          at_one
);
  localparam int DW = wdt_pkg::DIGIT_W;

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_dec;
  logic [N_DIGITS:0] borrow;

  assign borrow[0] = 1'b1;

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_dig
    wdt_pkg::bcd_digit_t cur;
    logic                zero;
    assign cur  = cnt_q[i*DW +: DW];
    assign zero = (cur == '0);
    assign borrow[i+1] = borrow[i] & zero;
    assign cnt_dec[i*DW +: DW] = !borrow[i] ? cur :
                                 zero ? wdt_pkg::BCD_MAX : cur - 1'b1;
  end

  assign at_one = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_dec;
  end
endmodule

// File: rtl/wdt_bcd_timer.sv
module wdt_bcd_timer #(
  parameter int N_DIGITS = 4,
  localparam int N_REGS  = N_DIGITS / 2,
  localparam int SEL_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_100hz,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [7:0]       acc_wdata,
  output logic [7:0]       acc_rdata,
  output logic             wdt_flag,
  output logic             alarm_evt
);
  localparam int PW = N_REGS * wdt_pkg::BYTE_W;

  logic [PW-1:0] period_q;
  logic [PW-1:0] period_d;
  logic          enabled;
  logic          at_one;
  logic          fire;
  logic          load;
  logic          dec;

  wdt_period_regs #(.N_REGS(N_REGS), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_en && acc_wr),
    .sel     (acc_sel),
    .wr_data (acc_wdata),
    .rd_data (acc_rdata),
    .period_q(period_q),
    .period_d(period_d)
  );

  assign enabled = (period_q != '0);
  assign fire    = tick_100hz && enabled && at_one && !acc_en;
  assign load    = acc_en || fire;
  assign dec     = tick_100hz && enabled && !at_one && !acc_en;

  wdt_bcd_down #(.N_DIGITS(N_DIGITS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(acc_en ? period_d : period_q),
    .dec     (dec),
    .at_one  (at_one)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_flag  <= 1'b0;
      alarm_evt <= 1'b0;
    end else begin
      alarm_evt <= fire;
      if (acc_en)    wdt_flag <= 1'b0;
      else if (fire) wdt_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_bcd_timer_chk.sv
module wdt_bcd_timer_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_100hz,
  input logic          acc_en,
  input logic          acc_wr,
  input logic [PW-1:0] period,
  input logic          wdt_flag,
  input logic          alarm_evt
);
  a_r3_evt_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> wdt_flag);

  a_r5_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> (!wdt_flag && !alarm_evt));

  a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0 && !acc_en) |=> !alarm_evt);

  a_r10_no_tick_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_100hz |=> !alarm_evt);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_flag && !acc_en) |=> wdt_flag);

  a_r2_period_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr) |=> $stable(period));
endmodule

bind wdt_bcd_timer wdt_bcd_timer_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_100hz(tick_100hz),
  .acc_en    (acc_en),
  .acc_wr    (acc_wr),
  .period    (period_q),
  .wdt_flag  (wdt_flag),
  .alarm_evt (alarm_evt)
);

// File: tb/wdt_bcd_timer_test.sv
module wdt_bcd_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100hz = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic [0:0] acc_sel = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic       wdt_flag;
  logic       alarm_evt;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wdt_bcd_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .wdt_flag(wdt_flag), .alarm_evt(alarm_evt)
  );

  // {fraction byte, seconds byte, idle cycles between ticks}
  localparam logic [23:0] VEC [0:5] = '{
    24'h03_00_00, 24'h10_00_01, 24'h01_00_00,
    24'h00_01_02, 24'h00_10_00, 24'h99_99_00
  };

  function automatic int bcd_ticks(input logic [7:0] c, input logic [7:0] d);
    return 1000 * int'(d[7:4]) + 100 * int'(d[3:0]) + 10 * int'(c[7:4]) + int'(c[3:0]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic access(input bit wr, input bit sel, input logic [7:0] data,
                        output logic [7:0] rd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_sel = sel; acc_wdata = data;
    #1 rd = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  // Ticks until the first alarm event; also flags any event on idle edges (R10).
  task automatic count_ticks(input int gap, input int maxn, output int n, output int idle_hits);
    n = -1; idle_hits = 0;
    for (int i = 1; i <= maxn; i++) begin
      tick_100hz = 1'b1;
      @(negedge clk);
      tick_100hz = 1'b0;
      if (alarm_evt) begin n = i; break; end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (alarm_evt) idle_hits++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int n, idle, exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(wdt_flag == 1'b0 && alarm_evt == 1'b0, "R1 outputs", int'(wdt_flag), 0);
    rst_n = 1'b1;
    access(1'b0, 1'b0, 8'h00, rd); check(rd == 8'h00, "R1 fraction reg", rd, 0);
    access(1'b0, 1'b1, 8'h00, rd); check(rd == 8'h00, "R1 seconds reg", rd, 0);

    // Table: R3 first alarm, R4 repeat, R8 borrow, R10 gaps
    for (int v = 0; v < 6; v++) begin
      logic [7:0] c, d;
      int g;
      c = VEC[v][23:16]; d = VEC[v][15:8]; g = int'(VEC[v][7:0]);
      exp = bcd_ticks(c, d);
      access(1'b1, 1'b0, c, rd);
      access(1'b1, 1'b1, d, rd);
      count_ticks(g, exp + 5, n, idle);
      check(n == exp, "R3 R8 first alarm ticks", n, exp);
      check(idle == 0, "R10 idle edges", idle, 0);
      check(wdt_flag == 1'b1, "R3 flag set", int'(wdt_flag), 1);
      count_ticks(g, exp + 5, n, idle);
      check(n == exp, "R4 repeat ticks", n, exp);
      check(wdt_flag == 1'b1, "R4 flag held", int'(wdt_flag), 1);
    end

    // R9 event lasts one cycle
    @(negedge clk);
    check(alarm_evt == 1'b0, "R9 single cycle event", int'(alarm_evt), 0);

    // R2 read-back returns entered value, not the count
    access(1'b0, 1'b0, 8'h00, rd); check(rd == 8'h99, "R2 fraction readback", rd, 8'h99);
    access(1'b0, 1'b1, 8'h00, rd); check(rd == 8'h99, "R2 seconds readback", rd, 8'h99);

    // R5 read restarts and clears flag
    access(1'b1, 1'b1, 8'h00, rd);
    access(1'b1, 1'b0, 8'h04, rd);
    count_ticks(0, 10, n, idle);
    check(wdt_flag == 1'b1, "R5 flag before read", int'(wdt_flag), 1);
    count_ticks(0, 3, n, idle);
    access(1'b0, 1'b1, 8'h00, rd);
    check(wdt_flag == 1'b0, "R5 flag cleared by read", int'(wdt_flag), 0);
    count_ticks(0, 10, n, idle);
    check(n == 4, "R5 full count after read", n, 4);

    // R7 access on expiring tick wins
    access(1'b1, 1'b0, 8'h02, rd);
    count_ticks(0, 1, n, idle);
    @(negedge clk);
    tick_100hz = 1'b1; acc_en = 1'b1; acc_wr = 1'b0; acc_sel = 1'b0;
    @(negedge clk);
    tick_100hz = 1'b0; acc_en = 1'b0;
    check(alarm_evt == 1'b0, "R7 no event on collision", int'(alarm_evt), 0);
    check(wdt_flag == 1'b0, "R7 flag low", int'(wdt_flag), 0);
    count_ticks(0, 10, n, idle);
    check(n == 2, "R7 reload after collision", n, 2);

    // R6 zero period disables
    access(1'b1, 1'b0, 8'h00, rd);
    access(1'b1, 1'b1, 8'h00, rd);
    count_ticks(0, 300, n, idle);
    check(n == -1, "R6 no alarm when zero", n, -1);
    check(wdt_flag == 1'b0, "R6 flag low", int'(wdt_flag), 0);

    finish_run();
  end
endmodule